// File: doc/BRIEF.md
# Scanned LED Matrix Register Display

This block lights a 16 by 16 LED dot matrix so that eight 16-bit register values can all be read at once. It does this by scanning the columns one at a time. A small counter picks one column per clock. The block then drives a one-hot column select, together with the row pattern that belongs to that column.

The display columns alternate between two kinds. Even columns carry register values: column 0 shows register 0, column 2 shows register 1, and so on up to column 14, which shows register 7. Every odd column is forced dark, so the registers stand apart on the display. In each register column, bit 0 is on the top row and the highest bit is on the bottom row. The row lines are active-low, so a 0 bit lights its LED and a blank column is driven with all ones.

The register values enter as one flat bus, with register k in bits [16k+15:16k]. The row pattern is a combinational function of the current column and the register inputs. A change on a register therefore shows up in the same cycle, with no added latency.

Top module: `scan_matrix_display`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets the scan position to column 0, so `colSel` reads 16'h0001 after that edge.
- R2: With `rst` low, each rising edge advances the scan position by one: column 15 is followed by column 0.
- R3: `colSel` is always one-hot, and bit n is high exactly when the scan position is n.
- R4: At even scan position 2k (k = 0..7), `rowData` equals register k, taken from `regBank[16k+15:16k]`.
- R5: At every odd scan position, `rowData` is 16'hFFFF, whatever the register inputs are.
- R6: Row r of the selected register column carries bit r of that register (row 0 at the top, row 15 at the bottom). The row value is not inverted, so a 0 bit drives its row line low and lights the LED.
- R7: `rowData` follows a change on `regBank` in the same cycle, with no register stage between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst | input | 1 | Synchronous reset, active high |
| regBank | input | 128 | Eight 16-bit register values, register k at bits [16k+15:16k] |
| colSel | output | 16 | One-hot column select, bit n for column n |
| rowData | output | 16 | Active-low row pattern for the selected column |

## Verification
The scan position moves one rising edge after each clock. `colSel` and `rowData` are combinational from that position, so they are due at the edge that advances it. The row pattern also depends directly on `regBank`, so it is due in the same cycle that `regBank` changes. The bench keeps its own column count, which advances on the same edges as the design. It changes `regBank` at the falling edge and compares both outputs one nanosecond later, so each sample lands on a settled value and not on a clock edge.

// File: rtl/scan_disp_pkg.sv
package scan_disp_pkg;
  // Upper bound on the index width carried in the strobe struct (up to 256 columns).
  localparam int unsigned SEL_W = 8;

  typedef struct packed {
    logic [SEL_W-1:0] colIdx;  // current scan column
    logic [SEL_W-1:0] regIdx;  // register shown when the column is not blank
    logic             blank;   // forced-dark spacer column
  } scan_strobe_t;
endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_disp_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8
) (
  input  logic         clk,
  input  logic         rst,
  output scan_strobe_t strobes
);
  localparam int unsigned COLS  = 2 * NUM_REGS;
  localparam int unsigned CNT_W = (COLS > 1) ? $clog2(COLS) : 1;

  logic [CNT_W-1:0] scanPos;

  always_ff @(posedge clk) begin
    if (rst) begin
      scanPos <= '0;
    end else if (scanPos == CNT_W'(COLS - 1)) begin
      scanPos <= '0;
    end else begin
      scanPos <= scanPos + 1'b1;
    end
  end

  always_comb begin
    strobes.colIdx = SEL_W'(scanPos);
    strobes.regIdx = SEL_W'(scanPos >> 1);
    strobes.blank  = scanPos[0];
  end
endmodule

// File: rtl/scan_datapath.sv
module scan_datapath
  import scan_disp_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned REG_W    = 16
) (
  input  scan_strobe_t                strobes,
  input  logic [NUM_REGS*REG_W-1:0]   regBank,
  output logic [2*NUM_REGS-1:0]       colSel,
  output logic [REG_W-1:0]            rowData
);
  localparam int unsigned COLS = 2 * NUM_REGS;

  genvar c;
  generate
    for (c = 0; c < COLS; c++) begin : g_col
      assign colSel[c] = (strobes.colIdx == SEL_W'(c));
    end
  endgenerate

  logic [REG_W-1:0] pickedReg;

  always_comb begin
    pickedReg = '1;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (strobes.regIdx == SEL_W'(k)) begin
        pickedReg = regBank[k*REG_W +: REG_W];
      end
    end
  end

  // Active-low rows: register bits pass straight through; spacer columns stay dark.
  assign rowData = strobes.blank ? '1 : pickedReg;
endmodule

// File: rtl/scan_matrix_display.sv
module scan_matrix_display
  import scan_disp_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned REG_W    = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_REGS*REG_W-1:0]   regBank,
  output logic [2*NUM_REGS-1:0]       colSel,
  output logic [REG_W-1:0]            rowData
);
  scan_strobe_t strobes;

  scan_ctrl #(.NUM_REGS(NUM_REGS)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes)
  );

  scan_datapath #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_dp (
    .strobes (strobes),
    .regBank (regBank),
    .colSel  (colSel),
    .rowData (rowData)
  );
endmodule

// File: rtl/scan_matrix_display_chk.sv
module scan_matrix_display_chk #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned REG_W    = 16
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NUM_REGS*REG_W-1:0] regBank,
  input logic [2*NUM_REGS-1:0]     colSel,
  input logic [REG_W-1:0]          rowData
);
  localparam int unsigned COLS = 2 * NUM_REGS;

  function automatic logic [COLS-1:0] oddCols();
    logic [COLS-1:0] m;
    m = '0;
    for (int i = 1; i < COLS; i += 2) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [COLS-1:0] ODD_MASK = oddCols();

  // R1: reset puts the scan on column 0
  a_r1_reset_col0: assert property (@(posedge clk) rst |=> (colSel == COLS'(1)));

  // R3: exactly one column is selected
  a_r3_onehot: assert property (@(posedge clk) disable iff (rst) $countones(colSel) == 1);

  // R2: column select rotates one step per edge, wrapping at the last column
  a_r2_advance: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (colSel == {$past(colSel[COLS-2:0]), $past(colSel[COLS-1])}));

  // R5: odd columns drive all rows high
  a_r5_odd_dark: assert property (@(posedge clk) disable iff (rst)
    (|(colSel & ODD_MASK)) |-> (rowData == '1));

  // R4, R6, R7: even column 2k shows register k bit-for-bit in the same cycle
  genvar k;
  generate
    for (k = 0; k < NUM_REGS; k++) begin : g_even
      a_r4_even_reg: assert property (@(posedge clk) disable iff (rst)
        colSel[2*k] |-> (rowData == regBank[k*REG_W +: REG_W]));
    end
  endgenerate
endmodule

bind scan_matrix_display scan_matrix_display_chk #(
  .NUM_REGS(NUM_REGS), .REG_W(REG_W)
) u_chk (.*);

// File: tb/scan_matrix_display_test.sv
`timescale 1ns/1ps
module scan_matrix_display_test;
  localparam int NR = 8;
  localparam int W  = 16;
  localparam int NC = 2 * NR;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NR*W-1:0] regBank = '0;
  logic [NC-1:0]   colSel;
  logic [W-1:0]    rowData;

  int checks = 0;
  int fails  = 0;
  int expPos = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  scan_matrix_display #(.NUM_REGS(NR), .REG_W(W)) uut (
    .clk(clk), .rst(rst), .regBank(regBank), .colSel(colSel), .rowData(rowData)
  );

  // Bench scan model: position per R1/R2
  always @(posedge clk) begin
    if (rst) expPos <= 0;
    else     expPos <= (expPos == NC - 1) ? 0 : expPos + 1;
  end

  function automatic logic [NC-1:0] expSel(int pos);
    return NC'(1) << pos;
  endfunction

  function automatic logic [W-1:0] expRow(int pos, logic [NR*W-1:0] rb);
    if (pos % 2 == 1) return '1;
    return rb[(pos/2)*W +: W];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (pos %0d)", req, act, exp, expPos);
    end
  endtask

  task automatic checkBoth(string selReq, string rowReq);
    check(selReq, 32'(colSel), 32'(expSel(expPos)));
    check(rowReq, 32'(rowData), 32'(expRow(expPos, regBank)));
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset column 0", 32'(colSel), 32'h1);
    rst = 1'b0;

    // R4/R5/R3: random register contents over several full scans
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      for (int k = 0; k < NR; k++) regBank[k*W +: W] = W'($urandom);
      #1;
      checkBoth("R3", (expPos % 2) ? "R5" : "R4");
    end

    // R2: wrap from column 15 to column 0
    while (expPos != NC - 1) @(negedge clk);
    #1 check("R2 last column", 32'(colSel), 32'(1 << (NC - 1)));
    @(negedge clk); #1;
    check("R2 wrap to 0", 32'(colSel), 32'h1);

    // R6: single-zero bit positions land on the matching rows
    regBank = '1;
    regBank[3*W + 0]  = 1'b0;
    regBank[5*W + 15] = 1'b0;
    while (expPos != 6) @(negedge clk);
    #1 check("R6 reg3 bit0 top row", 32'(rowData), 32'(16'hFFFE));
    while (expPos != 10) @(negedge clk);
    #1 check("R6 reg5 bit15 bottom row", 32'(rowData), 32'(16'h7FFF));

    // R5: odd column stays dark even with all-zero registers
    regBank = '0;
    @(negedge clk); #1;
    check("R5 odd dark", 32'(rowData), 32'(16'hFFFF));

    // R7: change register mid-column, row follows in same cycle
    while (expPos != 14) @(negedge clk);
    #1 check("R7 before change", 32'(rowData), 32'h0);
    regBank[7*W +: W] = 16'hA5C3;
    #1 check("R7 same-cycle update", 32'(rowData), 32'(16'hA5C3));

    // R1: reset in the middle of a scan
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; #1;
    check("R1 mid-run reset", 32'(colSel), 32'h1);
    check("R4 reg0 after reset", 32'(rowData), 32'(regBank[0 +: W]));

    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      regBank[(i % NR)*W +: W] = W'($urandom);
      #1;
      checkBoth("R3", (expPos % 2) ? "R5" : "R4");
    end

    finished = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule